// File: doc/BRIEF.md
# Narrow Slow-Memory Word Assembler

This block sits between a 32-bit on-chip read port and a slow external nonvolatile memory. The external device can be 8, 16 or 32 bits wide, and the width is chosen at run time. Every external access lasts a programmable number of wait states. When the device is narrower than 32 bits, the block makes several external accesses in a row at rising byte addresses. It packs the pieces into one 32-bit word, with the lowest address in the most significant position, and returns the word as a single-cycle valid pulse. With a byte-wide device and 24 wait states, one word takes roughly a hundred clock cycles.

A read is either a single word or a fixed-length burst of up to eight consecutive words. The requester keeps the block from the accepted request until the last word has been returned. During that time the chip-select stays asserted and any new request is ignored. The width code and the wait-state count are captured when a request is accepted. Software must write a valid width before the first read, because the configuration value after reset is not guaranteed to match the fitted device.

Top module: `nvm_word_assembler`

## Requirements
- R1: Reset state. While `rst` is high and in the first cycle after it falls, `rd_busy`, `ext_cs`, `ext_oe` and `rd_valid` are all 0.
- R2: Request acceptance. A request (`rd_req` high) is accepted only on a clock edge where `rd_busy` is 0. A request made while `rd_busy` is 1 has no effect on the addresses, data or timing of the transfer in progress.
- R3: Access timing. Every external access holds `ext_addr` constant, with `ext_cs` and `ext_oe` high, for exactly `cfg_wait`+1 cycles. The data is sampled in the last of those cycles. The first access starts in the cycle after acceptance, and the following accesses follow back to back.
- R4: Byte mode. Width code 2'b00 makes four accesses per word, at word base +0, +1, +2 and +3. Each access takes its byte from `ext_din[7:0]`.
- R5: Halfword mode. Width code 2'b01 makes two accesses per word, at word base +0 and +2. Each access takes its halfword from `ext_din[15:0]`.
- R6: Full-width mode. Width codes 2'b10 and 2'b11 make one access per word, at the word base. The access takes all 32 bits of `ext_din`.
- R7: Packing order. The piece read from the lowest address lands in `rd_data[31:24]` (byte mode) or `rd_data[31:16]` (halfword mode). Later pieces fill the lower positions in address order.
- R8: Word return. `rd_valid` is high for one cycle per word, in the cycle after the final piece of that word was sampled. `rd_data` is valid in that cycle.
- R9: Bursts. A request returns `rd_len`+1 words (1 to 8), at word bases `rd_addr`, +4, +8 and so on. `rd_last` is high only together with the final `rd_valid` of the request.
- R10: Bus hold. `rd_busy` is high from the cycle after acceptance up to and including the cycle of the final `rd_valid`. `ext_cs` is high in every cycle of the transfer except that final-valid cycle.
- R11: Configuration capture. `cfg_width` and `cfg_wait` are sampled at acceptance. Changing them during a transfer has no effect on that transfer.
- R12: Alignment. The two least significant bits of `rd_addr` are ignored, so every request starts on a 4-byte boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_width | input | 2 | Device width code: 00 = 8, 01 = 16, 10 or 11 = 32 bits |
| cfg_wait | input | WS_W | Wait states per external access |
| rd_req | input | 1 | Read request |
| rd_addr | input | AW | Byte address of the first word |
| rd_len | input | LEN_W | Number of words minus one |
| rd_busy | output | 1 | Transfer in progress; requests are ignored |
| rd_valid | output | 1 | One-cycle pulse carrying an assembled word |
| rd_data | output | 32 | Assembled word |
| rd_last | output | 1 | Marks the final word of a request |
| ext_addr | output | AW | External byte address |
| ext_cs | output | 1 | External chip-select |
| ext_oe | output | 1 | External output-enable |
| ext_din | input | 32 | External read data (narrow devices use the low lanes) |

## Verification
Four properties are checked on every cycle:
- the external address stays constant until the wait counter reaches its limit;
- the piece index never exceeds the pieces-per-word count of the captured width;
- the captured configuration does not move during a transfer;
- every returned word follows a final-piece sample, and the chip-select drops after the last word.

Only the bench scenarios can show the rest. These are the big-endian packing of real data, the choice of lane for each width, the exact address sequence across a burst, and the fact that requests and configuration writes made during a transfer are ignored. The bench checks them by comparing against a behavioural trace on every clock.

// File: rtl/nvm_asm_pkg.sv
package nvm_asm_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        WID_8   = 2'b00,
        WID_16  = 2'b01,
        WID_32  = 2'b10,
        WID_32B = 2'b11
    } width_e;

    // Number of external accesses needed for one 32-bit word
    function automatic logic [2:0] pieces_per_word(width_e w);
        case (w)
            WID_8:   return 3'd4;
            WID_16:  return 3'd2;
            default: return 3'd1;
        endcase
    endfunction

    // Address step between consecutive accesses
    function automatic logic [2:0] piece_bytes(width_e w);
        case (w)
            WID_8:   return 3'd1;
            WID_16:  return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    // Shift the accumulator up and append the newest piece at the bottom
    function automatic logic [WORD_W-1:0] pack_piece(logic [WORD_W-1:0] acc,
                                                     logic [WORD_W-1:0] din,
                                                     width_e w);
        case (w)
            WID_8:   return {acc[23:0], din[7:0]};
            WID_16:  return {acc[15:0], din[15:0]};
            default: return din;
        endcase
    endfunction

endpackage

// File: rtl/nvm_wait_timer.sv
module nvm_wait_timer #(
    parameter int WS_W = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic [WS_W-1:0] limit,
    output logic            last
);
    logic [WS_W-1:0] cnt;

    assign last = run && (cnt == limit);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (last) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/nvm_word_packer.sv
module nvm_word_packer
    import nvm_asm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sample,
    input  width_e            width,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] packed_next
);
    logic [WORD_W-1:0] acc;

    assign packed_next = pack_piece(acc, din, width);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
        end else if (sample) begin
            acc <= packed_next;
        end
    end
endmodule

// File: rtl/nvm_burst_seq.sv
module nvm_burst_seq
    import nvm_asm_pkg::*;
#(
    parameter int AW    = 24,
    parameter int WS_W  = 5,
    parameter int LEN_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_req,
    input  logic [AW-1:0]    rd_addr,
    input  logic [LEN_W-1:0] rd_len,
    input  logic [1:0]       cfg_width,
    input  logic [WS_W-1:0]  cfg_wait,
    input  logic             tmr_last,
    output logic             active,
    output logic             tail,
    output logic [AW-1:0]    addr,
    output width_e           width_q,
    output logic [WS_W-1:0]  wait_q,
    output logic             sample,
    output logic             word_end,
    output logic             final_word
);
    logic [1:0]       piece;
    logic [LEN_W-1:0] words_left;
    logic             accept;
    logic [2:0]       ppw;

    assign ppw        = pieces_per_word(width_q);
    assign accept     = rd_req && !active && !tail;
    assign sample     = active && tmr_last;
    assign word_end   = sample && ({1'b0, piece} == ppw - 3'd1);
    assign final_word = word_end && (words_left == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            active     <= 1'b0;
            tail       <= 1'b0;
            addr       <= '0;
            piece      <= '0;
            words_left <= '0;
            width_q    <= WID_32;
            wait_q     <= '0;
        end else begin
            tail <= final_word;
            if (accept) begin
                active     <= 1'b1;
                addr       <= rd_addr & ~AW'(3);
                piece      <= '0;
                words_left <= rd_len;
                width_q    <= width_e'(cfg_width);
                wait_q     <= cfg_wait;
            end else if (sample) begin
                addr  <= addr + AW'(piece_bytes(width_q));
                piece <= word_end ? 2'd0 : piece + 2'd1;
                if (word_end) begin
                    words_left <= words_left - 1'b1;
                end
                if (final_word) begin
                    active <= 1'b0;
                end
            end
        end
    end

    // R3: the address holds until the wait timer reports the sampling cycle
    a_r3_addr_held: assert property (@(posedge clk) disable iff (rst)
        (active && !tmr_last) |=> (addr == $past(addr)));

    // R4 R5 R6: piece index stays inside the captured width's piece count
    a_r4_piece_range: assert property (@(posedge clk) disable iff (rst)
        active |-> ({1'b0, piece} < ppw));

    // R11: captured configuration is frozen for the whole transfer
    a_r11_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
        (active && !final_word) |=> ($stable(width_q) && $stable(wait_q)));
endmodule

// File: rtl/nvm_word_assembler.sv
module nvm_word_assembler
    import nvm_asm_pkg::*;
#(
    parameter int AW    = 24,
    parameter int WS_W  = 5,
    parameter int LEN_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cfg_width,
    input  logic [WS_W-1:0]   cfg_wait,
    input  logic              rd_req,
    input  logic [AW-1:0]     rd_addr,
    input  logic [LEN_W-1:0]  rd_len,
    output logic              rd_busy,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_last,
    output logic [AW-1:0]     ext_addr,
    output logic              ext_cs,
    output logic              ext_oe,
    input  logic [WORD_W-1:0] ext_din
);
    logic              active;
    logic              tail;
    logic [AW-1:0]     addr;
    width_e            width_q;
    logic [WS_W-1:0]   wait_q;
    logic              sample;
    logic              word_end;
    logic              final_word;
    logic              tmr_last;
    logic [WORD_W-1:0] packed_next;

    nvm_burst_seq #(.AW(AW), .WS_W(WS_W), .LEN_W(LEN_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .rd_req     (rd_req),
        .rd_addr    (rd_addr),
        .rd_len     (rd_len),
        .cfg_width  (cfg_width),
        .cfg_wait   (cfg_wait),
        .tmr_last   (tmr_last),
        .active     (active),
        .tail       (tail),
        .addr       (addr),
        .width_q    (width_q),
        .wait_q     (wait_q),
        .sample     (sample),
        .word_end   (word_end),
        .final_word (final_word)
    );

    nvm_wait_timer #(.WS_W(WS_W)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .run   (active),
        .limit (wait_q),
        .last  (tmr_last)
    );

    nvm_word_packer u_packer (
        .clk         (clk),
        .rst         (rst),
        .sample      (sample),
        .width       (width_q),
        .din         (ext_din),
        .packed_next (packed_next)
    );

    assign rd_busy  = active || tail;
    assign ext_addr = addr;
    assign ext_cs   = active;
    assign ext_oe   = active;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_last  <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= word_end;
            rd_last  <= final_word;
            if (word_end) begin
                rd_data <= packed_next;
            end
        end
    end

    // R8: each returned word follows the sampling of a word's final piece
    a_r8_valid_after_piece: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(word_end));

    // R10: the chip-select is released once the last word has been handed over
    a_r10_release_after_last: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && rd_last) |=> (!ext_cs && !rd_busy));
endmodule

// File: tb/nvm_word_assembler_bench.sv
module nvm_word_assembler_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 24;
    localparam int WS_W = 5;
    localparam int LEN_W = 3;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [1:0]       cfg_width = 2'b01;
    logic [WS_W-1:0]  cfg_wait = '0;
    logic             rd_req = 1'b0;
    logic [AW-1:0]    rd_addr = '0;
    logic [LEN_W-1:0] rd_len = '0;
    logic             rd_busy, rd_valid, rd_last, ext_cs, ext_oe;
    logic [31:0]      rd_data, ext_din;
    logic [AW-1:0]    ext_addr;

    int n_cmp = 0;
    int n_bad = 0;
    logic [1:0] mem_width = 2'b00;

    always #(CLK_PERIOD/2) clk = ~clk;

    nvm_word_assembler #(.AW(AW), .WS_W(WS_W), .LEN_W(LEN_W)) u_nvm_word_assembler (
        .clk(clk), .rst(rst), .cfg_width(cfg_width), .cfg_wait(cfg_wait),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_len(rd_len),
        .rd_busy(rd_busy), .rd_valid(rd_valid), .rd_data(rd_data), .rd_last(rd_last),
        .ext_addr(ext_addr), .ext_cs(ext_cs), .ext_oe(ext_oe), .ext_din(ext_din)
    );

    function automatic logic [7:0] mem_byte(int a);
        return 8'((a * 37 + 11) & 255);
    endfunction

    // External device: narrow widths drive junk on the unused upper lanes
    function automatic logic [31:0] mem_word(int a, logic [1:0] w);
        if (w == 2'b00) return {8'hC3, 8'h3C, 8'h5A, mem_byte(a)};
        if (w == 2'b01) return {16'hBEEF, mem_byte(a), mem_byte(a + 1)};
        return {mem_byte(a), mem_byte(a + 1), mem_byte(a + 2), mem_byte(a + 3)};
    endfunction

    always_comb ext_din = mem_word(int'(ext_addr), mem_width);

    task automatic check(string tag, string what, longint act, longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s act=%0h exp=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Expected per-cycle trace, built from the requirements
    int   q_cs[$];
    int   q_addr[$];
    int   q_valid[$];
    logic [31:0] q_data[$];
    int   q_last[$];

    task automatic build_trace(logic [1:0] wc, int ws, int addr, int len);
        int pb, ppw, base, per, idx;
        q_cs.delete(); q_addr.delete(); q_valid.delete(); q_data.delete(); q_last.delete();
        pb   = (wc == 2'b00) ? 1 : (wc == 2'b01) ? 2 : 4;
        ppw  = 4 / pb;
        base = addr & ~3;
        per  = ws + 1;
        for (int w = 0; w <= len; w++) begin
            for (int p = 0; p < ppw; p++) begin
                for (int c = 0; c < per; c++) begin
                    q_cs.push_back(1);
                    q_addr.push_back(base + 4 * w + p * pb);
                    q_valid.push_back(0);
                    q_data.push_back('0);
                    q_last.push_back(0);
                end
            end
        end
        q_cs.push_back(0); q_addr.push_back(0); q_valid.push_back(0);
        q_data.push_back('0); q_last.push_back(0);
        for (int m = 1; m <= len + 1; m++) begin
            int a;
            a   = base + 4 * (m - 1);
            idx = m * ppw * per;
            q_valid[idx] = 1;
            q_data[idx]  = {mem_byte(a), mem_byte(a + 1), mem_byte(a + 2), mem_byte(a + 3)};
            q_last[idx]  = (m == len + 1) ? 1 : 0;
        end
    endtask

    task automatic compare_cycle(string tag, int i);
        check("R3", {tag, " ext_cs"}, ext_cs, q_cs[i]);
        check("R3", {tag, " ext_oe"}, ext_oe, q_cs[i]);
        if (q_cs[i] == 1) check(tag, "ext_addr", ext_addr, q_addr[i]);
        check("R8", {tag, " rd_valid"}, rd_valid, q_valid[i]);
        if (q_valid[i] == 1) check("R7", {tag, " rd_data"}, rd_data, q_data[i]);
        check("R9", {tag, " rd_last"}, rd_last, q_last[i]);
        check("R10", {tag, " rd_busy"}, rd_busy, 1);
    endtask

    task automatic run_read(logic [1:0] wc, int ws, int addr, int len, string tag, bit disturb);
        @(negedge clk);
        mem_width = wc;
        cfg_width = wc;
        cfg_wait  = WS_W'(ws);
        rd_addr   = AW'(addr);
        rd_len    = LEN_W'(len);
        rd_req    = 1'b1;
        build_trace(wc, ws, addr, len);
        for (int i = 0; i < q_cs.size(); i++) begin
            @(negedge clk);
            rd_req = 1'b0;
            if (disturb && i == 2) begin
                // R2 R11: request and config changes during a transfer are ignored
                rd_req    = 1'b1;
                rd_addr   = AW'(24'h00AA00);
                rd_len    = LEN_W'(5);
                cfg_width = 2'b10;
                cfg_wait  = WS_W'(7);
            end
            compare_cycle(tag, i);
        end
        @(negedge clk);
        rd_req = 1'b0;
        check("R10", {tag, " idle busy"}, rd_busy, 0);
        check("R10", {tag, " idle cs"}, ext_cs, 0);
        check("R8", {tag, " idle valid"}, rd_valid, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "busy in reset", rd_busy, 0);
        check("R1", "cs in reset", ext_cs, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "busy after reset", rd_busy, 0);
        check("R1", "cs after reset", ext_cs, 0);
        check("R1", "oe after reset", ext_oe, 0);
        check("R1", "valid after reset", rd_valid, 0);

        run_read(2'b00, 24, 32'h000100, 0, "R4 byte single", 1'b0);
        run_read(2'b01, 3,  32'h000200, 3, "R5 half burst", 1'b0);
        run_read(2'b10, 0,  32'h000400, 7, "R6 full burst", 1'b0);
        run_read(2'b11, 2,  32'h000510, 0, "R6 code3", 1'b0);
        run_read(2'b00, 1,  32'h000303, 2, "R12 R2 R11 unaligned", 1'b1);
        run_read(2'b01, 0,  32'h000602, 7, "R5 R12 half fast", 1'b1);
        run_read(2'b00, 0,  32'h0007F0, 7, "R4 R9 byte burst", 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog expired act=hung exp=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule